// File: doc/BRIEF.md
# Audio Sample-Rate Clock Generator

This block derives all audio timing for a converter pair from one master clock. It first forms a core tick, either on every master clock cycle or on every second one. From that tick it counts out separate frame rates for the record and playback paths, a bit-clock tick for master-mode serial transfers, and a tick for a buffered clock output. The clock output can be halved once more. Every output is a clock enable or a level in the master clock domain, so logic further along never needs a second clock.

The divide ratios are picked by a lookup on a joint key: a mode bit (standard audio master clock or 12 MHz bus clock), a 4-bit rate code and an oversampling-base bit. Some codes give different record and playback rates. The bus-clock mode needs ratios that are not powers of two, and some of them are odd. When the configuration inputs change, the block restarts every divider in the same cycle, so the frame and bit ticks stay aligned with each other. A combination that has no table entry falls back to the default ratio of its mode and raises an error flag.

Top module: `audio_clkgen`

## Requirements
- R1: With `coreDiv2`=0, `coreEn` is high on every cycle outside a restart cycle. With `coreDiv2`=1 it is high on every second cycle, and the first such cycle is the second cycle after a restart.
- R2: `clkOutEn` is high on every core tick when `outDiv2`=0. When `outDiv2`=1 it is high on every other core tick, starting with the first tick after a restart.
- R3: In standard mode (`usbMode`=0, `baseOsr`=0), record and playback frames are 256 core ticks long for codes 4'b0000 and 4'b1000, 1536 for code 4'b0011, and 128 for codes 4'b0111 and 4'b1111.
- R4: In standard mode, code 4'b0001 gives a record frame of 256 ticks and a playback frame of 1536 ticks. Code 4'b0010 swaps the two, for both settings of `baseOsr`. With `baseOsr`=1 the lengths are scaled as in R5.
- R5: In standard mode with `baseOsr`=1, every frame length from R3 and R4 is multiplied by 1.5, giving 384, 2304 and 192.
- R6: In standard mode, `bitEn` fires every 4 core ticks (`baseOsr`=0) or every 6 ticks (`baseOsr`=1). For codes 4'b0111 and 4'b1111 it fires every 2 ticks or every 3 ticks instead.
- R7: In bus-clock mode (`usbMode`=1), `bitEn` fires on every core tick. With `baseOsr`=0, both frame lengths are: 250 for code 0000, 1500 for 0011, 125 for 0111, 375 for 0110, 500 for 1110, 750 for 1010 and 1000 for 1000.
- R8: In bus-clock mode with `baseOsr`=1, both frame lengths are: 272 for code 1000, 1496 for 1011, 136 for 1111, 544 for 1101 and 1088 for 1100.
- R9: A frame strobe fires on the first core tick of each frame. The matching `*Lr` level is 1 (left) for the first ceil(N/2) ticks of an N-tick frame and 0 for the rest. An odd N therefore makes the left half one tick longer than the right half.
- R10: A combination not listed in R3 to R8 uses 256-tick frames with a 4-tick bit period in standard mode, and 250-tick frames with a 1-tick bit period in bus-clock mode. It holds `cfgErr` at 1 while that combination is in force. In all other cases `cfgErr` is 0.
- R11: In any cycle where the configuration inputs differ from those of the previous cycle, all strobes and both `*Lr` levels are 0. The cycle after that is phase zero of every divider.
- R12: After reset the block runs as standard mode, code 0000, `baseOsr`=0, with no divisions, starting from phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usbMode | input | 1 | 1 selects the 12 MHz bus-clock ratio set |
| rateCode | input | 4 | Sample-rate code |
| baseOsr | input | 1 | Oversampling base: 0 selects 256/250, 1 selects 384/272 |
| coreDiv2 | input | 1 | Halve the master clock to form the core tick |
| outDiv2 | input | 1 | Halve the core tick for the clock output |
| coreEn | output | 1 | Core clock enable |
| clkOutEn | output | 1 | Clock-output enable |
| bitEn | output | 1 | Master-mode bit-clock enable |
| recStb | output | 1 | Record frame start strobe |
| recLr | output | 1 | Record left/right phase, 1 = left |
| pbStb | output | 1 | Playback frame start strobe |
| pbLr | output | 1 | Playback left/right phase, 1 = left |
| cfgErr | output | 1 | Configuration has no table entry |

## Verification
The bound checker tests, on every cycle, the relations that hold for any configuration. These are: strobes only fire on core ticks, a frame strobe always lands in the left phase, core ticks alternate when halving is on, bus-clock mode gives a bit tick on every core tick, and a configuration change silences every output. The frame lengths themselves, the unequal record/playback pairs, the odd-ratio phase split, the error fallback and the placement of the restart need the bench. Its behavioural model replays each scenario for at least two full frames and compares every output on every cycle.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int CNT_W  = 12;  // frame counter width, holds up to 2304
  localparam int BIT_W  = 3;   // bit-period counter width, holds up to 6
  localparam int RATE_W = 4;
  localparam int NUM_CH = 2;   // record, playback

  typedef struct packed {
    logic              usb;
    logic [RATE_W-1:0] rate;
    logic              osr;
    logic              coreDiv2;
    logic              outDiv2;
  } cfg_t;

  // control to datapath: restart strobe plus the decoded ratios
  typedef struct packed {
    logic             restart;
    logic             coreDiv2;
    logic             outDiv2;
    logic [CNT_W-1:0] recDiv;
    logic [CNT_W-1:0] pbDiv;
    logic [BIT_W-1:0] bitDiv;
  } ctrl_t;
endpackage

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  cfg_t  cfgIn,
  output ctrl_t ctl,
  output logic  cfgErr
);
  cfg_t cfgQ;
  logic known;
  logic [CNT_W-1:0] recD, pbD;
  logic [BIT_W-1:0] bitD;
  logic [CNT_W-1:0] baseD, longD, shortD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgIn;
  end

  // standard-mode ratio family: base, six times base, half base
  assign baseD  = cfgQ.osr ? CNT_W'(384)  : CNT_W'(256);
  assign longD  = cfgQ.osr ? CNT_W'(2304) : CNT_W'(1536);
  assign shortD = cfgQ.osr ? CNT_W'(192)  : CNT_W'(128);

  always_comb begin
    known = 1'b1;
    recD  = baseD;
    pbD   = baseD;
    bitD  = cfgQ.osr ? BIT_W'(6) : BIT_W'(4);
    if (!cfgQ.usb) begin
      unique case (cfgQ.rate)
        4'b0000, 4'b1000: begin recD = baseD;  pbD = baseD;  end
        4'b0001:          begin recD = baseD;  pbD = longD;  end
        4'b0010:          begin recD = longD;  pbD = baseD;  end
        4'b0011:          begin recD = longD;  pbD = longD;  end
        4'b0111, 4'b1111: begin
          recD = shortD;
          pbD  = shortD;
          bitD = cfgQ.osr ? BIT_W'(3) : BIT_W'(2);
        end
        default: known = 1'b0;
      endcase
    end else begin
      bitD = BIT_W'(1);
      if (!cfgQ.osr) begin
        unique case (cfgQ.rate)
          4'b0000: recD = CNT_W'(250);
          4'b0011: recD = CNT_W'(1500);
          4'b0111: recD = CNT_W'(125);
          4'b0110: recD = CNT_W'(375);
          4'b1110: recD = CNT_W'(500);
          4'b1010: recD = CNT_W'(750);
          4'b1000: recD = CNT_W'(1000);
          default: known = 1'b0;
        endcase
      end else begin
        unique case (cfgQ.rate)
          4'b1000: recD = CNT_W'(272);
          4'b1011: recD = CNT_W'(1496);
          4'b1111: recD = CNT_W'(136);
          4'b1101: recD = CNT_W'(544);
          4'b1100: recD = CNT_W'(1088);
          default: known = 1'b0;
        endcase
      end
      pbD = recD;
    end
    if (!known) begin
      recD = cfgQ.usb ? CNT_W'(250) : CNT_W'(256);
      pbD  = recD;
      bitD = cfgQ.usb ? BIT_W'(1) : BIT_W'(4);
    end
  end

  assign cfgErr       = ~known;
  assign ctl.restart  = (cfgIn != cfgQ);
  assign ctl.coreDiv2 = cfgQ.coreDiv2;
  assign ctl.outDiv2  = cfgQ.outDiv2;
  assign ctl.recDiv   = recD;
  assign ctl.pbDiv    = pbD;
  assign ctl.bitDiv   = bitD;
endmodule

// File: rtl/clkgen_framediv.sv
`timescale 1ns/1ps
module clkgen_framediv #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] div,
  output logic         stb,
  output logic         lr
);
  logic [W-1:0] cnt;
  logic [W:0]   half;

  assign half = ({1'b0, div} + (W+1)'(1)) >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= (cnt == div - W'(1)) ? '0 : cnt + W'(1);
  end

  assign stb = tick && (cnt == '0);
  assign lr  = !restart && ({1'b0, cnt} < half);
endmodule

// File: rtl/clkgen_dp.sv
`timescale 1ns/1ps
module clkgen_dp
  import clkgen_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  ctrl_t ctl,
  output logic  coreEn,
  output logic  clkOutEn,
  output logic  bitEn,
  output logic  recStb,
  output logic  recLr,
  output logic  pbStb,
  output logic  pbLr
);
  logic divPh, coPh;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] chDiv [NUM_CH];
  logic [NUM_CH-1:0] chStb, chLr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divPh <= 1'b0;
    else if (ctl.restart) divPh <= 1'b0;
    else                  divPh <= ~divPh;
  end

  assign coreEn = !ctl.restart && (!ctl.coreDiv2 || divPh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coPh   <= 1'b0;
      bitCnt <= '0;
    end else if (ctl.restart) begin
      coPh   <= 1'b0;
      bitCnt <= '0;
    end else if (coreEn) begin
      coPh   <= ~coPh;
      bitCnt <= (bitCnt == ctl.bitDiv - BIT_W'(1)) ? '0 : bitCnt + BIT_W'(1);
    end
  end

  assign clkOutEn = coreEn && (!ctl.outDiv2 || !coPh);
  assign bitEn    = coreEn && (bitCnt == '0);

  assign chDiv[0] = ctl.recDiv;
  assign chDiv[1] = ctl.pbDiv;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_frame
    clkgen_framediv #(.W(CNT_W)) u_div (
      .clk     (clk),
      .rstN    (rstN),
      .restart (ctl.restart),
      .tick    (coreEn),
      .div     (chDiv[ch]),
      .stb     (chStb[ch]),
      .lr      (chLr[ch])
    );
  end

  assign recStb = chStb[0];
  assign recLr  = chLr[0];
  assign pbStb  = chStb[1];
  assign pbLr   = chLr[1];
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbMode,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              baseOsr,
  input  logic              coreDiv2,
  input  logic              outDiv2,
  output logic              coreEn,
  output logic              clkOutEn,
  output logic              bitEn,
  output logic              recStb,
  output logic              recLr,
  output logic              pbStb,
  output logic              pbLr,
  output logic              cfgErr
);
  cfg_t  cfgIn;
  ctrl_t ctl;

  assign cfgIn = '{usb: usbMode, rate: rateCode, osr: baseOsr,
                   coreDiv2: coreDiv2, outDiv2: outDiv2};

  clkgen_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgIn  (cfgIn),
    .ctl    (ctl),
    .cfgErr (cfgErr)
  );

  clkgen_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .coreEn   (coreEn),
    .clkOutEn (clkOutEn),
    .bitEn    (bitEn),
    .recStb   (recStb),
    .recLr    (recLr),
    .pbStb    (pbStb),
    .pbLr     (pbLr)
  );
endmodule

// File: rtl/clkgen_chk.sv
`timescale 1ns/1ps
module clkgen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       usbMode,
  input logic [3:0] rateCode,
  input logic       baseOsr,
  input logic       coreDiv2,
  input logic       outDiv2,
  input logic       coreEn,
  input logic       clkOutEn,
  input logic       bitEn,
  input logic       recStb,
  input logic       recLr,
  input logic       pbStb,
  input logic       pbLr
);
  logic [7:0] cfgVec;
  logic       seen;

  assign cfgVec = {usbMode, rateCode, baseOsr, coreDiv2, outDiv2};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  // R1
  core_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreDiv2 && coreEn |=> !coreEn);

  // R1
  core_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    seen && $stable(cfgVec) && !coreDiv2 |-> coreEn);

  // R2
  clkout_on_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkOutEn |-> coreEn);

  // R6
  bit_on_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |-> coreEn);

  // R7
  usb_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    usbMode && coreEn |-> bitEn);

  // R9
  rec_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    recStb |-> recLr);

  // R9
  pb_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    pbStb |-> pbLr);

  // R11
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    seen && !$stable(cfgVec) |->
      !coreEn && !clkOutEn && !bitEn && !recStb && !pbStb && !recLr && !pbLr);
endmodule

bind audio_clkgen clkgen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .usbMode  (usbMode),
  .rateCode (rateCode),
  .baseOsr  (baseOsr),
  .coreDiv2 (coreDiv2),
  .outDiv2  (outDiv2),
  .coreEn   (coreEn),
  .clkOutEn (clkOutEn),
  .bitEn    (bitEn),
  .recStb   (recStb),
  .recLr    (recLr),
  .pbStb    (pbStb),
  .pbLr     (pbLr)
);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic usbMode = 1'b0, baseOsr = 1'b0, coreDiv2 = 1'b0, outDiv2 = 1'b0;
  logic [3:0] rateCode = 4'b0000;
  logic coreEn, clkOutEn, bitEn, recStb, recLr, pbStb, pbLr, cfgErr;

  audio_clkgen dut (
    .clk(clk), .rstN(rstN), .usbMode(usbMode), .rateCode(rateCode),
    .baseOsr(baseOsr), .coreDiv2(coreDiv2), .outDiv2(outDiv2),
    .coreEn(coreEn), .clkOutEn(clkOutEn), .bitEn(bitEn),
    .recStb(recStb), .recLr(recLr), .pbStb(pbStb), .pbLr(pbLr),
    .cfgErr(cfgErr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] cfgM;
  int t;
  int sinceRst;

  function automatic logic [7:0] curCfg();
    return {usbMode, rateCode, baseOsr, coreDiv2, outDiv2};
  endfunction

  // ratio table taken from R3..R8 and R10
  function automatic void decode(input logic [7:0] c, output int rd, output int pd,
                                 output int bd, output bit err);
    bit u, o;
    int base;
    logic [3:0] code;
    u = c[7]; code = c[6:3]; o = c[2];
    err = 0;
    base = o ? 384 : 256;
    rd = 0; pd = 0; bd = 0;
    if (!u) begin
      bd = o ? 6 : 4;
      case (code)
        4'd0, 4'd8:  begin rd = base; pd = base; end
        4'd1:        begin rd = base; pd = base * 6; end
        4'd2:        begin rd = base * 6; pd = base; end
        4'd3:        begin rd = base * 6; pd = base * 6; end
        4'd7, 4'd15: begin rd = base / 2; pd = base / 2; bd = o ? 3 : 2; end
        default: err = 1;
      endcase
    end else begin
      bd = 1;
      if (!o) begin
        case (code)
          4'd0: rd = 250;  4'd3: rd = 1500; 4'd7: rd = 125; 4'd6: rd = 375;
          4'd14: rd = 500; 4'd10: rd = 750; 4'd8: rd = 1000;
          default: err = 1;
        endcase
      end else begin
        case (code)
          4'd8: rd = 272;  4'd11: rd = 1496; 4'd15: rd = 136;
          4'd13: rd = 544; 4'd12: rd = 1088;
          default: err = 1;
        endcase
      end
      pd = rd;
    end
    if (err) begin
      rd = u ? 250 : 256; pd = rd; bd = u ? 1 : 4;
    end
  endfunction

  function automatic string frameTag(input logic [7:0] c);
    int rd, pd, bd;
    bit err;
    decode(c, rd, pd, bd, err);
    if (err) return "R10";
    if (c[7]) return c[2] ? "R8" : "R7";
    if (c[6:3] == 4'd1 || c[6:3] == 4'd2) return "R4";
    return c[2] ? "R5" : "R3";
  endfunction

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      cfgM = 8'h00; t = 0; sinceRst = 0;
    end else begin
      sinceRst++;
      if (curCfg() != cfgM) begin cfgM = curCfg(); t = 0; end
      else t++;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int rd, pd, bd, k;
      bit err, chg, d2, od2, ce;
      string tf, tg;
      decode(cfgM, rd, pd, bd, err);
      chg = (curCfg() != cfgM);
      d2 = cfgM[1]; od2 = cfgM[0];
      ce = chg ? 1'b0 : (d2 ? (t % 2 == 1) : 1'b1);
      k = d2 ? t / 2 : t;
      tf = frameTag(cfgM);
      tg = chg ? "R11" : (sinceRst == 0 ? "R12" : "");
      chk(tg == "" ? "R1" : tg, "coreEn", coreEn, ce);
      chk(tg == "" ? "R2" : tg, "clkOutEn", clkOutEn, ce && (!od2 || (k % 2 == 0)));
      chk(tg == "" ? (cfgM[7] ? "R7" : "R6") : tg, "bitEn", bitEn, ce && (k % bd == 0));
      chk(tg == "" ? tf : tg, "recStb", recStb, ce && (k % rd == 0));
      chk(tg == "" ? tf : tg, "pbStb", pbStb, ce && (k % pd == 0));
      chk(tg == "" ? "R9" : tg, "recLr", recLr, !chg && ((k % rd) < (rd + 1) / 2));
      chk(tg == "" ? "R9" : tg, "pbLr", pbLr, !chg && ((k % pd) < (pd + 1) / 2));
      chk("R10", "cfgErr", cfgErr, err);
    end
  end

  task automatic run(input bit u, input logic [3:0] code, input bit o,
                     input bit d, input bit od, input int extra);
    int rd, pd, bd, n;
    bit err;
    decode({u, code, o, d, od}, rd, pd, bd, err);
    n = (rd > pd ? rd : pd) * (d ? 2 : 1) * 2 + 16 + extra;
    @(posedge clk); #1;
    usbMode = u; rateCode = code; baseOsr = o; coreDiv2 = d; outDiv2 = od;
    repeat (n) @(posedge clk);
  endtask

  task automatic cut(input bit u, input logic [3:0] code, input bit o,
                     input bit d, input int n);
    @(posedge clk); #1;
    usbMode = u; rateCode = code; baseOsr = o; coreDiv2 = d; outDiv2 = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (600) @(posedge clk);         // R12 default run
    // standard mode, R3/R4/R5/R6
    run(0, 4'b0011, 0, 0, 0, 0);
    run(0, 4'b0111, 0, 0, 1, 0);
    run(0, 4'b1000, 0, 1, 0, 0);
    run(0, 4'b1111, 0, 0, 0, 0);
    run(0, 4'b0001, 0, 0, 0, 0);
    run(0, 4'b0010, 0, 1, 1, 0);
    run(0, 4'b0000, 1, 0, 0, 0);
    run(0, 4'b0011, 1, 0, 0, 0);
    run(0, 4'b0111, 1, 1, 0, 0);
    run(0, 4'b0001, 1, 0, 1, 0);
    // bus-clock mode, R7/R8 (odd ratios 125, 375)
    run(1, 4'b0000, 0, 0, 0, 0);
    run(1, 4'b0011, 0, 0, 0, 0);
    run(1, 4'b0111, 0, 0, 1, 0);
    run(1, 4'b0110, 0, 1, 0, 0);
    run(1, 4'b1110, 0, 0, 0, 0);
    run(1, 4'b1010, 0, 0, 0, 0);
    run(1, 4'b1000, 0, 0, 0, 0);
    run(1, 4'b1000, 1, 0, 0, 0);
    run(1, 4'b1011, 1, 0, 0, 0);
    run(1, 4'b1111, 1, 1, 1, 0);
    run(1, 4'b1101, 1, 0, 0, 0);
    run(1, 4'b1100, 1, 0, 0, 0);
    // undefined combinations, R10
    run(0, 4'b0100, 0, 0, 0, 0);
    run(0, 4'b0110, 1, 0, 0, 0);
    run(1, 4'b0001, 0, 0, 0, 0);
    run(1, 4'b0000, 1, 1, 0, 0);
    // mid-frame changes, R11
    cut(1, 4'b0111, 0, 0, 37);
    cut(0, 4'b0111, 1, 1, 11);
    cut(0, 4'b0111, 1, 0, 1);
    cut(1, 4'b0110, 0, 0, 2);
    run(0, 4'b0000, 0, 0, 0, 0);
    // reset with a non-default configuration held, R12 then R11
    @(posedge clk); #1;
    usbMode = 1; rateCode = 4'b0111; baseOsr = 0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (400) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule